// File: doc/BRIEF.md
# Pulse-Length Modulated Bit Transmitter

This block sends a command frame from a reader to a tag. Every bit goes out as a short pulse on the modulation output, which switches the field off. The time from the start of one pulse to the start of the next carries the bit value, and a one takes longer than a zero. All timing is counted in carrier periods. A one-cycle `tick` enable marks each carrier period, so the block does not depend on its system clock rate.

A frame is loaded from a parallel buffer together with its length and a start strobe. On request, the frame opens with a start sequence: a normal zero bit, then a pulse followed by an overlong gap that no data bit can produce. Every frame closes with a single end pulse. The block then pulses `done` and returns the output low, which leaves the field on.

Top module: `plm_tx`

## Requirements
- R1: After reset and whenever idle, `mod_out`, `busy` and `done` are all low.
- R2: Every slot (data bit, start-sequence part and end pulse) begins with `mod_out` high for exactly `T_LOW` ticks and then low for the rest of the slot.
- R3: A zero bit slot lasts `T_ZERO` ticks and a one bit slot lasts `T_ONE` ticks, both counted from the rising edge of the slot's pulse; the next slot's pulse starts directly after.
- R4: The data bits are sent in buffer order, `frame[0]` first, for `frame_len` bits; a length above `MAX_BITS` is sent as `MAX_BITS`.
- R5: With `sof_en` high at start, the data is preceded by a zero bit slot of `T_ZERO` ticks and then a code-violation slot of `T_CV` ticks (pulse of `T_LOW`, gap to `T_CV`).
- R6: After the last data bit, an end pulse of `T_LOW` ticks is sent, after which `mod_out` is low.
- R7: `done` is high for exactly one clock, in the first cycle after the end pulse's last tick, and `busy` falls in that same cycle.
- R8: A start strobe while `busy` is high is ignored and does not change the frame being sent.
- R9: Only clock cycles with `tick` high advance the slot timing, and `mod_out` holds its value across cycles without a tick.
- R10: A frame with `frame_len` zero consists of the end pulse alone, or of the start sequence followed by the end pulse when `sof_en` is high.
- R11: `mod_out` rises in the first cycle after an accepted start, before any tick is counted; a start in the cycle where `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable marking each carrier period |
| start | input | 1 | Start strobe, accepted when idle |
| sof_en | input | 1 | Prefix the frame with the start sequence |
| frame | input | MAX_BITS | Frame bits, index 0 sent first |
| frame_len | input | LEN_W | Number of data bits to send |
| mod_out | output | 1 | Modulation output, high turns the field off |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of the frame |

## Verification
A start sampled at a clock edge takes effect at that same edge. `busy` and `mod_out` therefore rise in the cycle that follows the edge, and every later change of `mod_out` appears in the cycle after the edge that sampled the matching `tick`. `done` appears in the cycle after the edge that consumes the end pulse's last tick. The bench's reference model steps once per clock. It applies the inputs that were present at the last edge, then compares all three outputs at the falling edge that follows, before any input changes. The frame's waveform is prebuilt as one level per tick, each tagged with its requirement, and this is what keeps the expected values aligned to those delays under dense, sparse and single-cycle tick patterns.

// File: rtl/plm_tx.sv
module plm_tx #(
  parameter int MAX_BITS = 32,
  parameter int T_LOW    = 6,
  parameter int T_ZERO   = 20,
  parameter int T_ONE    = 28,
  parameter int T_CV     = 36,
  localparam int LEN_W   = $clog2(MAX_BITS + 1),
  localparam int T_MAX   = (T_CV > T_ONE) ? T_CV : T_ONE,
  localparam int CNT_W   = $clog2(T_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                start,
  input  logic                sof_en,
  input  logic [MAX_BITS-1:0] frame,
  input  logic [LEN_W-1:0]    frame_len,
  output logic                mod_out,
  output logic                busy,
  output logic                done
);

  generate
    if (!(T_LOW > 0 && T_LOW < T_ZERO && T_ZERO < T_ONE && T_CV > T_LOW))
      $error("plm_tx: slot counts must satisfy 0 < T_LOW < T_ZERO < T_ONE and T_CV > T_LOW");
  endgenerate

  localparam logic [CNT_W-1:0] LOW_C  = CNT_W'(T_LOW);
  localparam logic [CNT_W-1:0] ZERO_E = CNT_W'(T_ZERO - 1);
  localparam logic [CNT_W-1:0] ONE_E  = CNT_W'(T_ONE - 1);
  localparam logic [CNT_W-1:0] CV_E   = CNT_W'(T_CV - 1);
  localparam logic [CNT_W-1:0] LOW_E  = CNT_W'(T_LOW - 1);
  localparam logic [LEN_W-1:0] MAX_L  = LEN_W'(MAX_BITS);

  typedef enum logic [2:0] {S_IDLE, S_SOF, S_CV, S_DATA, S_EOF} state_t;

  state_t              state;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    last;
  logic [MAX_BITS-1:0] shreg;
  logic [LEN_W-1:0]    left;
  logic [LEN_W-1:0]    len_eff;
  logic                slot_end;

  assign len_eff  = (frame_len > MAX_L) ? MAX_L : frame_len;
  assign busy     = (state != S_IDLE);
  assign mod_out  = busy && (cnt < LOW_C);
  assign slot_end = tick && (cnt == last);

  always_comb begin
    case (state)
      S_SOF:   last = ZERO_E;
      S_CV:    last = CV_E;
      S_DATA:  last = shreg[0] ? ONE_E : ZERO_E;
      default: last = LOW_E;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      shreg <= '0;
      left  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          shreg <= frame;
          left  <= len_eff;
          cnt   <= '0;
          if (sof_en)             state <= S_SOF;
          else if (len_eff == '0) state <= S_EOF;
          else                    state <= S_DATA;
        end
      end else if (slot_end) begin
        cnt <= '0;
        case (state)
          S_SOF: state <= S_CV;
          S_CV:  state <= (left == '0) ? S_EOF : S_DATA;
          S_DATA: begin
            shreg <= shreg >> 1;
            left  <= left - 1'b1;
            if (left == LEN_W'(1)) state <= S_EOF;
          end
          default: begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        endcase
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R9
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !start) |=> $stable(mod_out));

  // R11
  first_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mod_out);

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $fell(mod_out)) |-> (cnt == LOW_C));

  // R7
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && !mod_out));

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !slot_end) |=> busy);

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !done);

endmodule

// File: tb/tb_plm_tx.sv
module tb_plm_tx;
  localparam int MAX_BITS = 32;
  localparam int T_LOW = 6, T_ZERO = 20, T_ONE = 28, T_CV = 36;
  localparam int LEN_W = $clog2(MAX_BITS + 1);

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start = 1'b0, sof_en = 1'b0;
  logic [MAX_BITS-1:0] frame = '0;
  logic [LEN_W-1:0] frame_len = '0;
  logic mod_out, busy, done;

  plm_tx #(.MAX_BITS(MAX_BITS), .T_LOW(T_LOW), .T_ZERO(T_ZERO), .T_ONE(T_ONE), .T_CV(T_CV)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .sof_en(sof_en),
    .frame(frame), .frame_len(frame_len), .mod_out(mod_out), .busy(busy), .done(done));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, div = 1;
  bit finished = 0;
  bit active = 0, done_exp = 0, in_reset = 1;
  bit wave[$];
  string tags[$];
  int p = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic add_slot(input int len, input string tag);
    for (int i = 0; i < len; i++) begin
      wave.push_back(i < T_LOW);
      tags.push_back(tag);
    end
  endtask

  task automatic build(input bit sof, input logic [MAX_BITS-1:0] f, input int len);
    int n;
    wave.delete(); tags.delete();
    n = (len > MAX_BITS) ? MAX_BITS : len;
    if (sof) begin
      add_slot(T_ZERO, "R5");
      add_slot(T_CV, "R5");
    end
    for (int i = 0; i < n; i++) add_slot(f[i] ? T_ONE : T_ZERO, f[i] ? "R3" : "R4");
    add_slot(T_LOW, (n == 0) ? "R10" : "R6");
    tags[0] = "R11";
  endtask

  task automatic cycle();
    @(negedge clk);
    cyc++;
    done_exp = 0;
    if (in_reset) begin
      active = 0;
    end else if (active) begin
      if (tick) begin
        p++;
        if (p == wave.size()) begin
          active = 0;
          done_exp = 1;
        end
      end
    end else if (start) begin
      build(sof_en, frame, int'(frame_len));
      active = 1;
      p = 0;
    end
    if (active) begin
      chk(mod_out == wave[p], (tick == 1'b0 && p > 0) ? "R9" : tags[p], "mod_out", mod_out, wave[p]);
      chk(busy == 1'b1, "R8", "busy", busy, 1);
      chk(done == 1'b0, "R7", "done", done, 0);
    end else begin
      chk(mod_out == 1'b0, "R1", "mod_out idle", mod_out, 0);
      chk(busy == 1'b0, done_exp ? "R7" : "R1", "busy idle", busy, 0);
      chk(done == done_exp, done_exp ? "R7" : "R1", "done", done, done_exp);
    end
    tick = (div == 0) ? ((cyc % 7) == 3 || (cyc % 5) == 0) : ((cyc % div) == 0);
  endtask

  task automatic send(input bit sof, input logic [MAX_BITS-1:0] f, input int len);
    sof_en = sof; frame = f; frame_len = LEN_W'(len); start = 1'b1;
    cycle();
    start = 1'b0; sof_en = 1'b0; frame = '0; frame_len = '0;
  endtask

  task automatic run_out();
    for (int i = 0; i < 20000 && (active || done_exp); i++) cycle();
    cycle();
  endtask

  initial begin
    repeat (3) cycle();
    rst_n = 1'b1;
    in_reset = 0;
    repeat (3) cycle();
    // R1 R3 R4 R6 R7: plain frame, tick every cycle
    div = 1;
    send(1'b0, 32'h0000_00A5, 8);
    run_out();
    // R5 R9: start sequence, sparse ticks
    div = 3;
    send(1'b1, 32'h0000_0136, 9);
    run_out();
    // R10: empty frames with and without start sequence
    div = 2;
    send(1'b0, 32'hFFFF_FFFF, 0);
    run_out();
    send(1'b1, 32'h0, 0);
    run_out();
    // R4: full width and over-length clamp, irregular ticks
    div = 0;
    send(1'b0, 32'hC3A5_0F81, MAX_BITS);
    run_out();
    send(1'b1, 32'h1234_5678, MAX_BITS + 1);
    run_out();
    // R8: start strobes while busy are ignored
    div = 1;
    send(1'b0, 32'h0000_000B, 4);
    repeat (30) cycle();
    sof_en = 1'b1; frame = 32'hFFFF_FFFF; frame_len = LEN_W'(MAX_BITS); start = 1'b1;
    repeat (15) cycle();
    start = 1'b0; sof_en = 1'b0;
    run_out();
    // R11: start accepted in the done cycle
    send(1'b0, 32'h2, 2);
    for (int i = 0; i < 2000 && !done_exp; i++) cycle();
    send(1'b0, 32'h1, 3);
    run_out();
    repeat (5) cycle();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule